// File: doc/BRIEF.md
# E1 Frame Alignment Synchronizer

This block recovers frame alignment from a serial E1 (PCM30) bit stream. Bits arrive one per clock cycle in which the bit-enable input is high. Each frame is 256 bits long. Its first eight bits form an alignment slot. In even frames the slot carries the full word `10011011`. In odd frames only the first three bits, `110`, are significant.

A three-state controller drives the search. While hunting, the controller compares the last eight received bits with the even word after every accepted bit. The first match fixes a tentative frame phase. The block then checks only one slot per frame, expecting the odd and even patterns in turn. After three correct checks in a row it declares alignment. Once aligned, it drops back to hunting only after four wrong slots in a row.

The outputs are:
- an alignment flag;
- a one-clock frame-start strobe;
- the bit position within the frame;
- a flag that marks the current frame as odd.

Downstream logic uses these to demultiplex timeslots.

Top module: `e1_frame_sync`

## Requirements
- R1: After synchronous reset the block is hunting. `in_frame`, `frame_start`, `odd_frame` and `bit_pos` are all 0.
- R2: Each accepted bit enters bit 0 of an 8-bit window that shifts left, so the first bit received ends in bit 7. The even word 10011011 is therefore sent left digit first.
- R3: While hunting, every accepted bit that completes the even word moves the block to verification. The following clock shows `bit_pos` = 8 and `odd_frame` = 0; that bit was position 7 of an even frame.
- R4: A clock with `bit_en` low changes neither the window, `bit_pos`, `odd_frame` nor the controller state.
- R5: Outside hunting, one check is made per frame, on the accepted bit at position 7. The expected pattern alternates, and the first check after a hunt hit expects the odd pattern. Any failed check during verification returns the block to hunting, and the failing bit is not itself searched.
- R6: `in_frame` rises on the third consecutive correct check after a hunt hit, and not before.
- R7: While aligned, `in_frame` falls on the fourth consecutive failed check. Any correct check resets the failure run.
- R8: `frame_start` is high for exactly one clock, following each accepted position-7 bit while verifying or aligned, and following a hunt hit. Whenever it is high, `bit_pos` reads 8.
- R9: `odd_frame` toggles when the bit at position 255 is accepted outside hunting. At each check it gives the parity of the frame being checked.
- R10: In an odd slot only bits 7..5 of the window (value 110) are compared. The other five bits have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Marks a clock that carries a new line bit |
| bit_in | input | 1 | Serial line bit |
| in_frame | output | 1 | High while frame alignment is held |
| frame_start | output | 1 | One-clock strobe after each alignment slot |
| bit_pos | output | 8 | Position of the next bit within the frame |
| odd_frame | output | 1 | Parity of the current frame (1 = odd) |

## Verification
The embedded properties assume that `bit_en` may be high on any clock or none. They assume nothing about line content, so any bit pattern is legal stimulus.

The bench places the even word and the odd prefix only in the alignment slots. The filler bits it draws at random never contain two zeros in a row. This prevents a false even word from forming while the block hunts, so the expected alignment phase is always the one the bench intended.

Idle clocks of random length are inserted between bits to exercise the enable. A directed odd slot with all-zero free bits, together with failure runs of exactly three and exactly four, covers the threshold cases.

// File: rtl/e1fs_pkg.sv
package e1fs_pkg;

    localparam int DEF_FRAME_BITS  = 256;
    localparam int DEF_SLOT_BITS   = 8;
    localparam int DEF_PREFIX_BITS = 3;
    localparam int DEF_GAIN_CHECKS = 3;
    localparam int DEF_LOSE_CHECKS = 4;
    localparam logic [DEF_SLOT_BITS-1:0]   DEF_EVEN_WORD  = 8'b1001_1011;
    localparam logic [DEF_PREFIX_BITS-1:0] DEF_ODD_PREFIX = 3'b110;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCK   = 2'd2
    } sync_state_e;

    // Result of comparing the window (including the bit being accepted).
    typedef struct packed {
        logic even_hit;
        logic odd_hit;
    } slot_match_t;

    // Frame timing seen by the controller.
    typedef struct packed {
        logic boundary;  // accepted bit closes the alignment slot
        logic odd;       // frame under way is odd
    } frame_tick_t;

    function automatic logic slot_ok(input slot_match_t m, input logic odd);
        return odd ? m.odd_hit : m.even_hit;
    endfunction

endpackage

// File: rtl/e1fs_shifter.sv
module e1fs_shifter
    import e1fs_pkg::*;
#(
    parameter int SLOT_BITS   = DEF_SLOT_BITS,
    parameter int PREFIX_BITS = DEF_PREFIX_BITS,
    parameter logic [SLOT_BITS-1:0]   EVEN_WORD  = DEF_EVEN_WORD,
    parameter logic [PREFIX_BITS-1:0] ODD_PREFIX = DEF_ODD_PREFIX
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bit_en,
    input  logic        bit_in,
    output slot_match_t match
);

    logic [SLOT_BITS-1:0] win_q;
    logic [SLOT_BITS-1:0] win_nxt;

    assign win_nxt = {win_q[SLOT_BITS-2:0], bit_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
        end else if (bit_en) begin
            win_q <= win_nxt;
        end
    end

    // Compare on the window as it will be once the current bit is in.
    assign match.even_hit = (win_nxt == EVEN_WORD);
    assign match.odd_hit  = (win_nxt[SLOT_BITS-1 -: PREFIX_BITS] == ODD_PREFIX);

    // R2: newest bit lands in bit 0
    a_r2_lsb_entry: assert property (@(posedge clk) disable iff (rst)
        bit_en |=> win_q[0] == $past(bit_in));

    // R4: window frozen without enable
    a_r4_window_hold: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(win_q));

endmodule

// File: rtl/e1fs_timebase.sv
module e1fs_timebase
    import e1fs_pkg::*;
#(
    parameter int FRAME_BITS = DEF_FRAME_BITS,
    parameter int SLOT_BITS  = DEF_SLOT_BITS,
    localparam int POS_W     = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic             realign,
    input  logic             aligned,
    output logic [POS_W-1:0] pos,
    output frame_tick_t      tick
);

    localparam logic [POS_W-1:0] LAST_POS  = POS_W'(FRAME_BITS - 1);
    localparam logic [POS_W-1:0] SLOT_LAST = POS_W'(SLOT_BITS - 1);
    localparam logic [POS_W-1:0] AFTER_HIT = POS_W'(SLOT_BITS);

    logic odd_q;

    function automatic logic [POS_W-1:0] pos_inc(input logic [POS_W-1:0] p);
        return (p == LAST_POS) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            pos   <= '0;
            odd_q <= 1'b0;
        end else if (realign) begin
            pos   <= AFTER_HIT;
            odd_q <= 1'b0;
        end else if (bit_en) begin
            pos <= pos_inc(pos);
            if (aligned && pos == LAST_POS) begin
                odd_q <= ~odd_q;
            end
        end
    end

    assign tick.boundary = bit_en && aligned && (pos == SLOT_LAST);
    assign tick.odd      = odd_q;

    // R3: position advances by one per accepted bit unless realigned
    a_r3_pos_step: assert property (@(posedge clk) disable iff (rst)
        (bit_en && !realign) |=> pos == (($past(pos) == LAST_POS) ? '0 : $past(pos) + 1'b1));

    // R4: nothing moves without enable
    a_r4_pos_hold: assert property (@(posedge clk) disable iff (rst)
        (!bit_en && !realign) |=> ($stable(pos) && $stable(odd_q)));

    // R9: parity only changes across a frame wrap
    a_r9_parity_wrap: assert property (@(posedge clk) disable iff (rst)
        (!realign && !(bit_en && pos == LAST_POS)) |=> $stable(odd_q));

endmodule

// File: rtl/e1fs_ctrl.sv
module e1fs_ctrl
    import e1fs_pkg::*;
#(
    parameter int GAIN_CHECKS = DEF_GAIN_CHECKS,
    parameter int LOSE_CHECKS = DEF_LOSE_CHECKS,
    localparam int GOOD_W     = $clog2(GAIN_CHECKS + 1),
    localparam int ERR_W      = $clog2(LOSE_CHECKS + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bit_en,
    input  slot_match_t match,
    input  frame_tick_t tick,
    output sync_state_e state,
    output logic        realign
);

    localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(GAIN_CHECKS - 1);
    localparam logic [ERR_W-1:0]  ERR_LAST  = ERR_W'(LOSE_CHECKS - 1);

    logic [GOOD_W-1:0] good_cnt;
    logic [ERR_W-1:0]  err_cnt;
    logic              chk_ok;

    assign realign = bit_en && (state == ST_HUNT) && match.even_hit;
    assign chk_ok  = slot_ok(match, tick.odd);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_HUNT;
            good_cnt <= '0;
            err_cnt  <= '0;
        end else begin
            unique case (state)
                ST_HUNT: begin
                    if (realign) begin
                        state    <= ST_VERIFY;
                        good_cnt <= '0;
                    end
                end
                ST_VERIFY: begin
                    if (tick.boundary) begin
                        if (!chk_ok) begin
                            state <= ST_HUNT;
                        end else if (good_cnt == GOOD_LAST) begin
                            state   <= ST_LOCK;
                            err_cnt <= '0;
                        end else begin
                            good_cnt <= good_cnt + 1'b1;
                        end
                    end
                end
                ST_LOCK: begin
                    if (tick.boundary) begin
                        if (chk_ok) begin
                            err_cnt <= '0;
                        end else if (err_cnt == ERR_LAST) begin
                            state   <= ST_HUNT;
                            err_cnt <= '0;
                        end else begin
                            err_cnt <= err_cnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_HUNT;
            endcase
        end
    end

    // R3: hunting is left only on an accepted even hit
    a_r3_hunt_exit: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HUNT && !(bit_en && match.even_hit)) |=> state == ST_HUNT);

    // R5: alignment is never declared straight from hunting
    a_r5_no_skip: assert property (@(posedge clk) disable iff (rst)
        state == ST_HUNT |=> state != ST_LOCK);

    // R6: lock entry only after the full run of good checks
    a_r6_lock_entry: assert property (@(posedge clk) disable iff (rst)
        (state != ST_LOCK ##1 state == ST_LOCK) |->
            ($past(state) == ST_VERIFY && $past(good_cnt) == GOOD_LAST));

    // R7: lock exit only after the full run of bad checks
    a_r7_lock_exit: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOCK ##1 state != ST_LOCK) |->
            ($past(err_cnt) == ERR_LAST && $past(tick.boundary)));

    // R7: failure run never exceeds its limit
    a_r7_err_bound: assert property (@(posedge clk) disable iff (rst)
        err_cnt <= ERR_LAST);

endmodule

// File: rtl/e1_frame_sync.sv
module e1_frame_sync
    import e1fs_pkg::*;
#(
    parameter int FRAME_BITS  = DEF_FRAME_BITS,
    parameter int SLOT_BITS   = DEF_SLOT_BITS,
    parameter int PREFIX_BITS = DEF_PREFIX_BITS,
    parameter int GAIN_CHECKS = DEF_GAIN_CHECKS,
    parameter int LOSE_CHECKS = DEF_LOSE_CHECKS,
    parameter logic [SLOT_BITS-1:0]   EVEN_WORD  = DEF_EVEN_WORD,
    parameter logic [PREFIX_BITS-1:0] ODD_PREFIX = DEF_ODD_PREFIX,
    localparam int POS_W = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic             bit_in,
    output logic             in_frame,
    output logic             frame_start,
    output logic [POS_W-1:0] bit_pos,
    output logic             odd_frame
);

    slot_match_t match;
    frame_tick_t tick;
    sync_state_e state;
    logic        realign;
    logic        aligned;

    assign aligned = (state != ST_HUNT);

    e1fs_shifter #(
        .SLOT_BITS  (SLOT_BITS),
        .PREFIX_BITS(PREFIX_BITS),
        .EVEN_WORD  (EVEN_WORD),
        .ODD_PREFIX (ODD_PREFIX)
    ) u_shift (
        .clk   (clk),
        .rst   (rst),
        .bit_en(bit_en),
        .bit_in(bit_in),
        .match (match)
    );

    e1fs_timebase #(
        .FRAME_BITS(FRAME_BITS),
        .SLOT_BITS (SLOT_BITS)
    ) u_time (
        .clk    (clk),
        .rst    (rst),
        .bit_en (bit_en),
        .realign(realign),
        .aligned(aligned),
        .pos    (bit_pos),
        .tick   (tick)
    );

    e1fs_ctrl #(
        .GAIN_CHECKS(GAIN_CHECKS),
        .LOSE_CHECKS(LOSE_CHECKS)
    ) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .bit_en (bit_en),
        .match  (match),
        .tick   (tick),
        .state  (state),
        .realign(realign)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_start <= 1'b0;
        end else begin
            frame_start <= realign || tick.boundary;
        end
    end

    assign in_frame  = (state == ST_LOCK);
    assign odd_frame = tick.odd;

    // R8: strobe lasts one clock
    a_r8_strobe_single: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);

    // R8: strobe coincides with the first bit after the slot
    a_r8_strobe_pos: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> bit_pos == POS_W'(SLOT_BITS));

endmodule

// File: tb/tb_e1_frame_sync.sv
`timescale 1ns/1ps
module tb_e1_frame_sync;

    localparam logic [7:0] EVEN_W = 8'b1001_1011;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       bit_in = 1'b0;
    logic       in_frame, frame_start, odd_frame;
    logic [7:0] bit_pos;

    int   n_checks = 0;
    int   n_errs   = 0;
    bit   finished = 0;
    logic prev_bit = 1'b0;
    logic par      = 1'b0;
    logic s_fs;
    logic [7:0] s_pos;

    always #10 clk = ~clk;

    e1_frame_sync dut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
        .in_frame(in_frame), .frame_start(frame_start),
        .bit_pos(bit_pos), .odd_frame(odd_frame)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Filler never holds two zeros in a row, so no false even word appears.
    function automatic logic filler();
        return (prev_bit == 1'b0) ? 1'b1 : 1'($urandom % 2);
    endfunction

    task automatic send_bit(input logic b);
        int n;
        bit_in = b;
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        prev_bit = b;
        s_fs  = frame_start;
        s_pos = bit_pos;
        n = $urandom_range(0, 2);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (k == 0 && s_fs) begin
                chk("R8 strobe single", frame_start, 0);
                chk("R4 idle hold", bit_pos, s_pos);
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        bit_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        prev_bit = 1'b0;
        chk("R1 in_frame", in_frame, 0);
        chk("R1 frame_start", frame_start, 0);
        chk("R1 bit_pos", bit_pos, 0);
        chk("R1 odd_frame", odd_frame, 0);
    endtask

    task automatic preamble();
        int n;
        n = $urandom_range(20, 300);
        for (int i = 0; i < n; i++) send_bit(1'b0);
    endtask

    // kind: 0 good, 1 bad, 2 good odd with zero free bits, 3 even word in odd slot
    task automatic send_frame(input logic odd, input int kind, input logic exp_in,
                              input string req);
        logic [7:0] w;
        logic       p;
        if (!odd) begin
            w = (kind == 1) ? (EVEN_W ^ (8'h01 << $urandom_range(0, 7))) : EVEN_W;
        end else begin
            case (kind)
                0: begin
                    w[7:5] = 3'b110;
                    p = 1'b0;
                    for (int i = 4; i >= 0; i--) begin
                        w[i] = (p == 1'b0) ? 1'b1 : 1'($urandom % 2);
                        p = w[i];
                    end
                end
                1: begin
                    case ($urandom % 3)
                        0: w[7:5] = 3'b010;
                        1: w[7:5] = 3'b100;
                        default: w[7:5] = 3'b111;
                    endcase
                    w[4:0] = 5'b11111;
                end
                2: w = 8'b1100_0000;
                default: w = EVEN_W;
            endcase
        end
        for (int i = 7; i >= 0; i--) send_bit(w[i]);
        chk(req, s_fs ? {31'd0, in_frame} : {31'd0, in_frame}, {31'd0, exp_in});
        chk("R8 strobe after slot", s_fs, 1);
        chk("R3 R8 position after slot", s_pos, 8);
        chk("R9 parity", odd_frame, odd);
        for (int i = 8; i < 256; i++) send_bit(filler());
    endtask

    task automatic nxt(input int kind, input logic exp_in, input string req);
        send_frame(par, kind, exp_in, req);
        par = ~par;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errs++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        int run;
        void'($urandom(32'd20240611));
        do_reset();

        // Hunt, verify and gain (R2 R3 R6), then hold and lose (R7 R10)
        preamble();
        par = 1'b0;
        nxt(0, 0, "R2 R3 hunt hit");
        nxt(0, 0, "R6 one good check");
        nxt(0, 0, "R6 two good checks");
        nxt(0, 1, "R6 third good check");
        run = 0;
        for (int f = 0; f < 8; f++) begin
            if (run < 3 && ($urandom % 3) == 0) begin
                nxt(1, 1, "R7 random bad held");
                run++;
            end else begin
                nxt(0, 1, "R7 random good held");
                run = 0;
            end
        end
        nxt(0, 1, "R7 good clears run");
        if (par == 1'b1) nxt(0, 1, "R7 good even");
        nxt(1, 1, "R7 bad 1");
        nxt(1, 1, "R7 bad 2");
        nxt(1, 1, "R7 bad 3");
        nxt(2, 1, "R10 odd free bits zero");
        nxt(1, 1, "R7 bad 1 after clear");
        nxt(1, 1, "R7 bad 2 after clear");
        nxt(1, 1, "R7 bad 3 after clear");
        nxt(1, 0, "R7 fourth bad drops");

        // Verify failure on the third check, then re-hunt (R5)
        do_reset();
        preamble();
        par = 1'b0;
        nxt(0, 0, "R3 hunt hit");
        nxt(0, 0, "R5 check 1");
        nxt(0, 0, "R5 check 2");
        nxt(1, 0, "R5 third check fails");
        nxt(0, 0, "R3 R5 rehit after fail");
        nxt(0, 0, "R6 one");
        nxt(0, 0, "R6 two");
        nxt(0, 1, "R6 three");

        // Wrong parity in the first check (R5)
        do_reset();
        preamble();
        par = 1'b0;
        nxt(0, 0, "R3 hunt hit");
        nxt(3, 0, "R5 even word in odd slot fails");
        nxt(0, 0, "R3 rehit after parity fail");
        nxt(0, 0, "R6 one");
        nxt(0, 0, "R6 two");
        nxt(0, 1, "R6 three");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule